// File: doc/BRIEF.md
# Frame-DMA Channel Priority Arbiter

This block decides, every clock cycle, which of eight frame-DMA channels may use the shared memory engine. Six channels (0 to 5) move frames from memory into the switch. Two channels (6 and 7) move frames from the switch into memory. Each of the six inbound channels carries a port-select bit that attaches it to one of two CPU ports. Channel 6 drains CPU port 0 and channel 7 drains CPU port 1.

Outbound (extraction) traffic always beats inbound (injection) traffic. Inside one CPU port, the higher channel number wins. When both CPU ports have work in the winning class, the ports take turns. An injection channel that has begun a frame keeps its CPU port until it reports the end of that frame. No other injection channel on that port is served in the meantime.

The granted channel reports frame start and frame end on two strobes. These strobes refer to the grant that is visible on the outputs in the same cycle. The grant is registered, so it takes effect one cycle after the request inputs it was computed from.

Top module: `dma_chan_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, `gnt_vld` is 0 and `gnt_ch` is 0.
- R2: A channel whose `ch_en` bit is 0 is never granted, even when its `ch_req` bit is 1. A channel is eligible only when both bits are 1.
- R3: If channel 6 or channel 7 is eligible, the next grant goes to one of those two channels, whatever injection channels also request.
- R4: Suppose a CPU port is not held and injection wins the cycle. Among the eligible injection channels attached to that port, the one with the highest number is granted.
- R5: Port attachment works as follows. Bit i of `inj_port_sel` attaches injection channel i to CPU port 0 when it is 0, and to CPU port 1 when it is 1. Channel 6 belongs to port 0 and channel 7 to port 1.
- R6: The grant is registered. The outputs in cycle n+1 follow from the inputs in cycle n. When no channel is eligible, `gnt_vld` is 0 and `gnt_ch` is 0 in the next cycle.
- R7: When both CPU ports offer a candidate in the winning class, the port not served by the previous grant is chosen. After reset, port 0 is preferred first.
- R8: A port becomes held in one case. `frm_sof` is 1 and `frm_eof` is 0 while an injection channel is granted on that port. The port is then held by that channel. It is released when `frm_eof` is 1 while that channel is granted. If `frm_sof` and `frm_eof` are both 1 in one cycle, the port is not held.
- R9: While a port is held, only its owner can take an injection grant on that port. This stays true even when a higher-numbered injection channel on the port becomes eligible. If the owner is not eligible, the port offers no injection candidate.
- R10: An extraction channel can be granted on a held port. This does not release the hold. The owner resumes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | 8 | Per-channel request |
| ch_en | input | 8 | Per-channel enable |
| inj_port_sel | input | 6 | CPU-port select for injection channels 0..5 |
| frm_sof | input | 1 | Frame start from the currently granted channel |
| frm_eof | input | 1 | Frame end from the currently granted channel |
| gnt_ch | output | 3 | Granted channel index (0 when no grant) |
| gnt_vld | output | 1 | Grant valid |

## Verification
The bench builds the block with its package defaults: six injection channels and two CPU ports. With these values, every channel class, both port attachments and the two-way alternation can be reached in a few cycles. The directed phases cover several cases:
- disabled requesters
- extraction preempting injection
- a higher channel arriving while a lower one holds its port
- a one-cycle frame in which start and end coincide

Random phases at two request densities and with random port selects then mix holds, releases and alternation. They are compared against a behavioural model on every cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int INJ_CH = 6;
    localparam int PORTS  = 2;
    localparam int CH_N   = INJ_CH + PORTS;
    localparam int CH_W   = $clog2(CH_N);
    localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1;

    typedef logic [CH_W-1:0]   ch_t;
    typedef logic [PORT_W-1:0] port_t;

    typedef struct packed {
        logic vld;
        ch_t  ch;
    } cand_t;

    typedef struct packed {
        logic held;
        ch_t  owner;
    } own_t;

    function automatic ch_t ext_ch_of(input int p);
        return ch_t'(INJ_CH + p);
    endfunction

    function automatic logic is_ext(input ch_t c);
        return int'(c) >= INJ_CH;
    endfunction

    function automatic port_t ext_port_of(input ch_t c);
        return port_t'(int'(c) - INJ_CH);
    endfunction
endpackage

// File: rtl/dma_own_track.sv
module dma_own_track
    import dma_arb_pkg::*;
#(
    parameter int PORT_ID = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  gnt_vld,
    input  ch_t   gnt_ch,
    input  port_t gnt_port,
    input  logic  frm_sof,
    input  logic  frm_eof,
    output own_t  own_nxt
);
    own_t own_q;
    logic hit;

    assign hit = gnt_vld && !is_ext(gnt_ch) && (int'(gnt_port) == PORT_ID);

    always_comb begin
        own_nxt = own_q;
        if (hit) begin
            if (frm_eof) begin
                own_nxt.held = 1'b0;
            end else if (frm_sof) begin
                own_nxt.held  = 1'b1;
                own_nxt.owner = gnt_ch;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= '0;
        end else begin
            own_q <= own_nxt;
        end
    end
endmodule

// File: rtl/dma_port_cand.sv
module dma_port_cand
    import dma_arb_pkg::*;
#(
    parameter int PORT_ID = 0
) (
    input  logic [CH_N-1:0]          elig,
    input  logic [INJ_CH*PORT_W-1:0] inj_port_sel,
    input  own_t                     own,
    output cand_t                    ext_c,
    output cand_t                    inj_c
);
    always_comb begin
        ext_c.ch  = ext_ch_of(PORT_ID);
        ext_c.vld = elig[ext_ch_of(PORT_ID)];
    end

    always_comb begin
        inj_c = '0;
        if (own.held) begin
            inj_c.vld = elig[own.owner];
            inj_c.ch  = own.owner;
        end else begin
            for (int i = 0; i < INJ_CH; i++) begin
                if (elig[i] && (int'(inj_port_sel[i*PORT_W +: PORT_W]) == PORT_ID)) begin
                    inj_c.vld = 1'b1;
                    inj_c.ch  = ch_t'(i);
                end
            end
        end
    end
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb
    import dma_arb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CH_N-1:0]          ch_req,
    input  logic [CH_N-1:0]          ch_en,
    input  logic [INJ_CH*PORT_W-1:0] inj_port_sel,
    input  logic                     frm_sof,
    input  logic                     frm_eof,
    output logic [CH_W-1:0]          gnt_ch,
    output logic                     gnt_vld
);
    logic [CH_N-1:0] elig;
    own_t            own_nxt [PORTS];
    cand_t           ext_c   [PORTS];
    cand_t           inj_c   [PORTS];
    cand_t           pc      [PORTS];
    logic            any_ext;

    logic  gnt_vld_q;
    ch_t   gnt_ch_q;
    port_t gnt_port_q;
    port_t last_q;

    logic  pick_v;
    ch_t   pick_c;
    port_t pick_p;

    assign elig = ch_req & ch_en;

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        dma_own_track #(.PORT_ID(p)) u_own (
            .clk      (clk),
            .rst      (rst),
            .gnt_vld  (gnt_vld_q),
            .gnt_ch   (gnt_ch_q),
            .gnt_port (gnt_port_q),
            .frm_sof  (frm_sof),
            .frm_eof  (frm_eof),
            .own_nxt  (own_nxt[p])
        );

        dma_port_cand #(.PORT_ID(p)) u_cand (
            .elig         (elig),
            .inj_port_sel (inj_port_sel),
            .own          (own_nxt[p]),
            .ext_c        (ext_c[p]),
            .inj_c        (inj_c[p])
        );
    end

    always_comb begin
        any_ext = 1'b0;
        for (int p = 0; p < PORTS; p++) begin
            any_ext = any_ext | ext_c[p].vld;
        end
        for (int p = 0; p < PORTS; p++) begin
            pc[p] = any_ext ? ext_c[p] : inj_c[p];
        end
    end

    always_comb begin
        int q;
        pick_v = 1'b0;
        pick_c = '0;
        pick_p = '0;
        for (int k = 0; k < PORTS; k++) begin
            q = (int'(last_q) + 1 + k) % PORTS;
            if (!pick_v && pc[q].vld) begin
                pick_v = 1'b1;
                pick_c = pc[q].ch;
                pick_p = port_t'(q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_vld_q  <= 1'b0;
            gnt_ch_q   <= '0;
            gnt_port_q <= '0;
            last_q     <= port_t'(PORTS - 1);
        end else begin
            gnt_vld_q  <= pick_v;
            gnt_ch_q   <= pick_c;
            gnt_port_q <= pick_p;
            if (pick_v) begin
                last_q <= pick_p;
            end
        end
    end

    assign gnt_ch  = gnt_ch_q;
    assign gnt_vld = gnt_vld_q;
endmodule

// File: rtl/dma_chan_arb_chk.sv
module dma_chan_arb_chk
    import dma_arb_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [CH_N-1:0]      ch_req,
    input logic [CH_N-1:0]      ch_en,
    input logic                 frm_sof,
    input logic                 frm_eof,
    input logic [CH_W-1:0]      gnt_ch,
    input logic                 gnt_vld,
    input port_t                gnt_port
);
    logic [CH_N-1:0] elig_d;
    logic            ext_d;
    logic            both_ext_d;

    always_ff @(posedge clk) begin
        elig_d <= ch_req & ch_en;
    end

    always_comb begin
        ext_d      = 1'b0;
        both_ext_d = 1'b1;
        for (int p = 0; p < PORTS; p++) begin
            ext_d      = ext_d | elig_d[INJ_CH + p];
            both_ext_d = both_ext_d & elig_d[INJ_CH + p];
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!gnt_vld && gnt_ch == '0));

    assert_only_eligible_R2: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> elig_d[gnt_ch]);

    assert_ext_first_R3: assert property (@(posedge clk) disable iff (rst)
        ext_d |-> (gnt_vld && is_ext(gnt_ch)));

    assert_idle_when_none_R6: assert property (@(posedge clk) disable iff (rst)
        (elig_d == '0) |-> (!gnt_vld && gnt_ch == '0));

    assert_ext_alternate_R7: assert property (@(posedge clk) disable iff (rst)
        (both_ext_d && $past(both_ext_d) && $past(gnt_vld)) |-> (gnt_ch != $past(gnt_ch)));

    assert_frame_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (gnt_vld && !is_ext(gnt_ch) && frm_sof && !frm_eof)
        |=> ((gnt_vld && !is_ext(gnt_ch) && gnt_port == $past(gnt_port))
             -> (gnt_ch == $past(gnt_ch))));
endmodule

bind dma_chan_arb dma_chan_arb_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ch_req   (ch_req),
    .ch_en    (ch_en),
    .frm_sof  (frm_sof),
    .frm_eof  (frm_eof),
    .gnt_ch   (gnt_ch),
    .gnt_vld  (gnt_vld),
    .gnt_port (gnt_port_q)
);

// File: tb/tb_dma_chan_arb.sv
module tb_dma_chan_arb;
    import dma_arb_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [CH_N-1:0]          ch_req = '0;
    logic [CH_N-1:0]          ch_en = '0;
    logic [INJ_CH*PORT_W-1:0] inj_port_sel = '0;
    logic                     frm_sof = 1'b0;
    logic                     frm_eof = 1'b0;
    logic [CH_W-1:0]          gnt_ch;
    logic                     gnt_vld;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_held [PORTS];
    int m_owner[PORTS];
    int m_last;
    int m_gv, m_gc, m_gp;
    string exp_tag = "R1";

    always #2 clk = ~clk;

    dma_chan_arb dut (
        .clk(clk), .rst(rst), .ch_req(ch_req), .ch_en(ch_en),
        .inj_port_sel(inj_port_sel), .frm_sof(frm_sof), .frm_eof(frm_eof),
        .gnt_ch(gnt_ch), .gnt_vld(gnt_vld)
    );

    task automatic model_reset();
        for (int p = 0; p < PORTS; p++) begin
            m_held[p] = 0;
            m_owner[p] = 0;
        end
        m_last = PORTS - 1;
        m_gv = 0; m_gc = 0; m_gp = 0;
    endtask

    task automatic model_step();
        int elig[CH_N];
        int anyx, found;
        int cv[PORTS];
        int cc[PORTS];
        int q;
        // frame ownership update from the grant currently shown
        if (m_gv != 0 && m_gc < INJ_CH) begin
            if (frm_eof) m_held[m_gp] = 0;
            else if (frm_sof) begin
                m_held[m_gp] = 1;
                m_owner[m_gp] = m_gc;
            end
        end
        for (int i = 0; i < CH_N; i++) elig[i] = (ch_req[i] && ch_en[i]) ? 1 : 0;
        anyx = 0;
        for (int p = 0; p < PORTS; p++) if (elig[INJ_CH + p] != 0) anyx = 1;
        for (int p = 0; p < PORTS; p++) begin
            if (anyx != 0) begin
                cv[p] = elig[INJ_CH + p];
                cc[p] = INJ_CH + p;
            end else if (m_held[p] != 0) begin
                cv[p] = elig[m_owner[p]];
                cc[p] = m_owner[p];
            end else begin
                cv[p] = 0; cc[p] = 0;
                for (int i = INJ_CH - 1; i >= 0; i--) begin
                    if (cv[p] == 0 && elig[i] != 0 && int'(inj_port_sel[i*PORT_W +: PORT_W]) == p) begin
                        cv[p] = 1; cc[p] = i;
                    end
                end
            end
        end
        found = 0; m_gc = 0; m_gp = 0;
        for (int k = 0; k < PORTS; k++) begin
            q = (m_last + 1 + k) % PORTS;
            if (found == 0 && cv[q] != 0) begin
                found = 1; m_gc = cc[q]; m_gp = q;
            end
        end
        m_gv = found;
        if (found != 0) m_last = m_gp;
    endtask

    task automatic check_out();
        total++;
        if (gnt_vld !== m_gv[0] || gnt_ch !== m_gc[CH_W-1:0]) begin
            bad++;
            $display("FAIL %s: actual vld=%0d ch=%0d expected vld=%0d ch=%0d at %0t",
                     exp_tag, gnt_vld, gnt_ch, m_gv, m_gc, $time);
        end
    endtask

    // one cycle: check the previous result, drive new stimulus, advance the model
    task automatic cyc(input logic [CH_N-1:0] rq, input logic [CH_N-1:0] en,
                       input logic [INJ_CH*PORT_W-1:0] sel, input logic sof,
                       input logic eof, input string tag);
        @(negedge clk);
        check_out();
        ch_req = rq; ch_en = en; inj_port_sel = sel; frm_sof = sof; frm_eof = eof;
        model_step();
        exp_tag = tag;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        total++;
        if (gnt_vld !== 1'b0 || gnt_ch !== '0) begin
            bad++;
            $display("FAIL R1: actual vld=%0d ch=%0d expected vld=0 ch=0", gnt_vld, gnt_ch);
        end
        rst = 1'b0;
        exp_tag = "R1";
        // R1 first cycle after reset, R2 disabled channels ignored
        cyc(8'hFF, 8'h00, 6'h00, 0, 0, "R2");
        cyc(8'hFF, 8'h08, 6'h00, 0, 0, "R2");
        cyc(8'h00, 8'hFF, 6'h00, 0, 0, "R6");
        // R3 extraction beats injection
        cyc(8'hA0, 8'hFF, 6'h00, 0, 0, "R3");
        cyc(8'h7F, 8'hFF, 6'h3F, 0, 0, "R3");
        // R4 R5 highest injection per port, port attachment
        cyc(8'h12, 8'hFF, 6'h00, 0, 0, "R4");
        cyc(8'h12, 8'hFF, 6'h10, 0, 0, "R5");
        cyc(8'h12, 8'hFF, 6'h10, 0, 0, "R5");
        cyc(8'h00, 8'hFF, 6'h00, 0, 0, "R6");
        // R7 alternation among extraction and among injection
        for (int n = 0; n < 4; n++) cyc(8'hC0, 8'hFF, 6'h00, 0, 0, "R7");
        for (int n = 0; n < 4; n++) cyc(8'h21, 8'hFF, 6'h20, 0, 0, "R7");
        cyc(8'h00, 8'hFF, 6'h00, 0, 0, "R6");
        // R8 R9 hold port 1 for channel 2 while channel 5 arrives
        cyc(8'h04, 8'hFF, 6'h24, 0, 0, "R8");
        cyc(8'h24, 8'hFF, 6'h24, 1, 0, "R8");
        cyc(8'h24, 8'hFF, 6'h24, 0, 0, "R9");
        cyc(8'h20, 8'hFF, 6'h24, 0, 0, "R9");
        cyc(8'h24, 8'hFF, 6'h24, 0, 0, "R9");
        // R10 extraction on held port, then owner resumes
        cyc(8'hA4, 8'hFF, 6'h24, 0, 0, "R10");
        cyc(8'h24, 8'hFF, 6'h24, 0, 0, "R10");
        cyc(8'h24, 8'hFF, 6'h24, 0, 1, "R8");
        cyc(8'h24, 8'hFF, 6'h24, 0, 0, "R4");
        // R8 single-cycle frame leaves the port free
        cyc(8'h24, 8'hFF, 6'h24, 1, 1, "R8");
        cyc(8'h04, 8'hFF, 6'h24, 0, 0, "R8");
        cyc(8'h04, 8'hFF, 6'h24, 1, 1, "R8");
        cyc(8'h24, 8'hFF, 6'h24, 0, 0, "R8");
        // random mixes at two densities
        for (int n = 0; n < 600; n++) begin
            logic [CH_N-1:0] r;
            r = CH_N'($urandom) & CH_N'($urandom);
            cyc(r, CH_N'($urandom) | CH_N'($urandom), (INJ_CH*PORT_W)'($urandom),
                ($urandom % 3) == 0, ($urandom % 4) == 0, "R9");
        end
        for (int n = 0; n < 600; n++) begin
            cyc(CH_N'($urandom) & 8'h3F, 8'hFF, (INJ_CH*PORT_W)'($urandom),
                ($urandom % 2) == 0, ($urandom % 5) == 0, "R8");
        end
        cyc(8'h00, 8'hFF, 6'h00, 0, 0, "R6");
        @(negedge clk);
        check_out();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule